// File: doc/BRIEF.md
# MDIO Management Command Controller

This block is a serial management engine for Ethernet PHYs, driven from a small register port. Software enables the management port, then writes one 32-bit maintenance word. The word already holds the start code, the opcode, the PHY address, the register number, the turnaround code and the data. The block sends 32 preamble ones. It then shifts the whole word out on MDIO, MSB first, with one bit per period of a divided management clock. A frame therefore lasts 64 MDC periods.

On a read, the block releases MDIO for the second half of the turnaround and for the data field. It samples the 16 data bits returned by the PHY and places them in the low half of the same maintenance register. The upper half keeps the command as it was written.

A status register carries an idle flag. Software polls this flag before a command, to know it may issue one, and after a command, to know that read data is ready. Only one frame can be in flight at a time. A maintenance write that arrives while a frame is running is dropped.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, the block is in this state:
  - control reads 0, status reads 0x4, maintenance reads 0;
  - MDC is low;
  - MDIO is not driven (output enable low).
- R2: Control register bit 4 enables the management port.
  - While the port is disabled, a maintenance write changes nothing: the register keeps its value, no frame starts and the idle flag stays set.
  - Clearing bit 4 during a frame stops the frame at once. The idle flag is set again, MDC goes low and MDIO is released.
- R3: A maintenance write is accepted when the port is enabled and idle.
  - The idle flag (status bit 2) is clear in the cycle after the accepting edge.
  - The flag is set again exactly 64 × CLK_DIV clock cycles after that edge.
- R4: A maintenance write made while a frame is busy is ignored. Neither the register contents nor the bits of the frame in flight change.
- R5: Each frame is 64 MDC periods long, with one bit per period, in this order:
  - 32 ones;
  - maintenance bits 31 down to 16;
  - maintenance bits 15 down to 0.
  On a write, the maintenance register is unchanged after the frame.
- R6: The MDC clock behaves as follows:
  - each period is CLK_DIV clock cycles long;
  - within a period, MDC is low for the first CLK_DIV/2 cycles and high for the rest;
  - MDC stays low while no frame runs.
- R7: The opcode decides whether the block drives MDIO.
  - A word with bit 29 set and bit 28 clear is a read. On a read, MDIO is driven through frame bit 46 (maintenance bit 17) and released from frame bit 47 (maintenance bit 16) to the end of the frame.
  - Any other opcode drives MDIO for all 64 bits.
- R8: On a read, the block samples mdio_i at the clock edge that raises MDC, during frame bits 48 to 63, MSB first.
  - When the frame ends, the sampled value lands in maintenance bits 15:0.
  - Bits 31:16 keep the written command.
- R9: MDIO and its output enable change only at the start of an MDC low phase. They are stable while MDC is high.
- R10: Register map:
  - address 0 is control (only bit 4 is stored; all other bits read 0);
  - address 1 is status (only bit 2 is non-zero);
  - address 2 is the maintenance word;
  - address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Output enable for the MDIO pad driver |
| mdio_i | input | 1 | Management data in from the pad |

## Verification
The hardest cases to reach from the ports are those that act on a frame already in progress: a second maintenance write arriving mid-frame, and the port being disabled mid-frame. The stimulus starts a command and counts clock edges to a known point inside the frame before it issues the disturbing write. It then checks that the bits seen on the wire, the register contents and the idle timing match either the first command or a clean stop.

The read path needs a PHY that answers at the right moment. The bench's PHY model tracks how many MDC rising edges have occurred. It updates mdio_i only while MDC is low, so each returned bit is already stable when the block samples it.

A sweep over every PHY address, with both read and write opcodes and varied data patterns, exercises every field bit of the frame.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int unsigned REG_AW = 2;
  localparam logic [REG_AW-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_STAT  = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_MAINT = 2'd2;

  localparam int unsigned WORD_W        = 32;
  localparam int unsigned DATA_W        = 16;
  localparam int unsigned CTRL_EN_BIT   = 4;
  localparam int unsigned STAT_IDLE_BIT = 2;
  localparam int unsigned OP_RD_BIT     = 29;
  localparam int unsigned OP_WR_BIT     = 28;

  typedef enum logic {
    XFER_DRIVE = 1'b0,
    XFER_READ  = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int unsigned CLK_DIV = 48
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic bit_end_o
);
  localparam int unsigned HALF = CLK_DIV / 2;
  localparam int unsigned CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(CLK_DIV - 1);
  localparam logic [CW-1:0] CNT_MID  = CW'(HALF - 1);
  localparam logic [CW-1:0] CNT_HIGH = CW'(HALF);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i)            cnt_q <= '0;
    else if (cnt_q == CNT_LAST) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign mdc_o     = run_i & (cnt_q >= CNT_HIGH);
  // edge on which mdc goes high: sample point
  assign rise_o    = run_i & (cnt_q == CNT_MID);
  assign bit_end_o = run_i & (cnt_q == CNT_LAST);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              rise_i,
  input  logic              bit_end_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              is_rd_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned FRAME_LEN = PRE_LEN + WORD_W;
  localparam int unsigned IW        = $clog2(FRAME_LEN + 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(FRAME_LEN - 1);
  localparam logic [IW-1:0] IDX_WORD = IW'(PRE_LEN);
  // frame index of word bit DATA_W (second turnaround) and DATA_W-1
  localparam logic [IW-1:0] IDX_REL  = IW'(PRE_LEN + WORD_W - 1 - DATA_W);
  localparam logic [IW-1:0] IDX_SMP  = IW'(PRE_LEN + WORD_W - DATA_W);

  logic              busy_q;
  xfer_dir_e         dir_q;
  logic [IW-1:0]     idx_q;
  logic [WORD_W-1:0] sh_q;
  logic [DATA_W-1:0] rx_q;
  logic              in_word;

  assign in_word = (idx_q >= IDX_WORD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      dir_q  <= XFER_DRIVE;
      idx_q  <= '0;
      sh_q   <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      dir_q  <= (word_i[OP_RD_BIT] && !word_i[OP_WR_BIT]) ? XFER_READ : XFER_DRIVE;
      idx_q  <= '0;
      sh_q   <= word_i;
    end else if (busy_q && bit_end_i) begin
      if (idx_q == IDX_LAST) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
      if (in_word) sh_q <= {sh_q[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        rx_q <= '0;
    else if (start_i && !busy_q)                        rx_q <= '0;
    else if (busy_q && rise_i && dir_q == XFER_READ && idx_q >= IDX_SMP)
      rx_q <= {rx_q[DATA_W-2:0], mdio_i};
  end

  assign busy_o    = busy_q;
  assign is_rd_o   = (dir_q == XFER_READ);
  assign done_o    = busy_q & bit_end_i & (idx_q == IDX_LAST) & ~abort_i;
  assign mdio_o    = in_word ? sh_q[WORD_W-1] : 1'b1;
  assign mdio_oe_o = busy_q & ~((dir_q == XFER_READ) & (idx_q >= IDX_REL));
  assign rd_data_o = rx_q;
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned CLK_DIV = 48,
  parameter int unsigned PRE_LEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic              en_q;
  logic [WORD_W-1:0] maint_q;
  logic              busy;
  logic              done;
  logic              is_rd;
  logic [DATA_W-1:0] rd_data;
  logic              rise;
  logic              bit_end;
  logic              wr_ctrl;
  logic              wr_maint;
  logic              start;
  logic              abort;

  assign wr_ctrl  = reg_we_i & (reg_addr_i == ADDR_CTRL);
  assign wr_maint = reg_we_i & (reg_addr_i == ADDR_MAINT);
  assign start    = wr_maint & en_q & ~busy;
  assign abort    = wr_ctrl & ~reg_wdata_i[CTRL_EN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= 1'b0;
    else if (wr_ctrl) en_q <= reg_wdata_i[CTRL_EN_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            maint_q <= '0;
    else if (start)         maint_q <= reg_wdata_i;
    else if (done && is_rd) maint_q[DATA_W-1:0] <= rd_data;
  end

  mdio_clk_gen #(
    .CLK_DIV (CLK_DIV)
  ) u_clk_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy),
    .mdc_o     (mdc_o),
    .rise_o    (rise),
    .bit_end_o (bit_end)
  );

  mdio_frame_engine #(
    .PRE_LEN (PRE_LEN)
  ) u_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .abort_i   (abort),
    .word_i    (reg_wdata_i),
    .rise_i    (rise),
    .bit_end_i (bit_end),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .done_o    (done),
    .is_rd_o   (is_rd),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .rd_data_o (rd_data)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_CTRL:  reg_rdata_o[CTRL_EN_BIT]   = en_q;
      ADDR_STAT:  reg_rdata_o[STAT_IDLE_BIT] = ~busy;
      ADDR_MAINT: reg_rdata_o                = maint_q;
      default:    reg_rdata_o                = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk
  import mdio_mgmt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              busy_i,
  input logic              mdc_i,
  input logic              mdio_i,
  input logic              mdio_oe_i,
  input logic [WORD_W-1:0] maint_i,
  input logic              we_i,
  input logic [REG_AW-1:0] addr_i
);
  // R6 / R7: bus quiet with no frame
  p_quiet_when_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!mdc_i && !mdio_oe_i));

  p_no_frame_disabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !busy_i);

  p_start_needs_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(we_i && addr_i == ADDR_MAINT && en_i));

  p_cmd_held_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(maint_i[WORD_W-1:DATA_W]));

  p_mdio_stable_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_i && $past(mdc_i)) |-> ($stable(mdio_i) && $stable(mdio_oe_i)));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_q),
  .busy_i    (busy),
  .mdc_i     (mdc_o),
  .mdio_i    (mdio_o),
  .mdio_oe_i (mdio_oe_o),
  .maint_i   (maint_q),
  .we_i      (reg_we_i),
  .addr_i    (reg_addr_i)
);

// File: tb/mdio_mgmt_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_tb;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;
  localparam int FLEN = 64;
  localparam int REL  = 47;
  localparam int SMP  = 48;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_MAINT = 2'd2, A_NONE = 2'd3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = A_STAT;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i = 1'b1;

  int n_tests = 0;
  int n_fail  = 0;

  logic [15:0] phy_data = '0;
  logic        cap_bit [FLEN];
  logic        cap_oe  [FLEN];
  int rise_cnt = 0, hi_cnt = 0, per_bad = 0, stab_bad = 0;
  int cyc = 0, last_rise = 0;
  logic prev_mdc = 1'b0, prev_mdio = 1'b1, prev_oe = 1'b0;

  always #2 clk_i = ~clk_i;

  mdio_mgmt_ctrl #(.CLK_DIV(DIV)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .mdc_o(mdc_o),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic phy_bit(input int k);
    if (k >= SMP && k < FLEN) return phy_data[FLEN-1-k];
    return 1'b1;
  endfunction

  // wire monitor and PHY model
  initial begin
    forever begin
      @(negedge clk_i);
      cyc++;
      if (mdc_o && !prev_mdc) begin
        if (rise_cnt < FLEN) begin
          cap_bit[rise_cnt] = mdio_o;
          cap_oe[rise_cnt]  = mdio_oe_o;
        end
        if (rise_cnt > 0 && (cyc - last_rise) != DIV) per_bad++;
        last_rise = cyc;
        rise_cnt++;
      end
      if (mdc_o) hi_cnt++;
      if (mdc_o && prev_mdc && (mdio_o !== prev_mdio || mdio_oe_o !== prev_oe)) stab_bad++;
      if (!mdc_o) mdio_i = phy_bit(rise_cnt);
      prev_mdc = mdc_o; prev_mdio = mdio_o; prev_oe = mdio_oe_o;
    end
  end

  task automatic clear_mon();
    rise_cnt = 0; hi_cnt = 0; per_bad = 0; stab_bad = 0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_addr_i = A_STAT;
  endtask

  task automatic reg_get(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  function automatic logic [31:0] mk_word(input bit rd, input int phy, input int rg,
                                           input logic [15:0] d);
    return 32'h4002_0000 | (rd ? 32'h2000_0000 : 32'h1000_0000) |
           (32'(phy) << 23) | (32'(rg) << 18) | {16'h0, d};
  endfunction

  task automatic start_cmd(input logic [31:0] w);
    logic [31:0] s;
    clear_mon();
    reg_write(A_MAINT, w);
    reg_get(A_STAT, s);
    check(s[2] == 1'b0, "R3", "idle after accept", s, 32'h0);
  endtask

  task automatic finish_cmd(input logic [31:0] w, input int exp_n, input logic [31:0] exp_maint);
    logic [31:0] s, m;
    int n = 1;
    bit rd = w[29] && !w[28];
    bit bits_ok = 1, oe_ok = 1;
    for (int i = 0; i < 200000; i++) begin
      @(negedge clk_i);
      reg_get(A_STAT, s);
      if (s[2]) break;
      n++;
    end
    check(n == exp_n, "R3", "busy cycles", n, exp_n);
    check(rise_cnt == FLEN, "R5", "mdc periods", rise_cnt, FLEN);
    for (int k = 0; k < FLEN; k++) begin
      logic eb = (k < 32) ? 1'b1 : w[FLEN-1-k];
      logic eo = rd ? (k < REL) : 1'b1;
      if ((!rd || k < REL) && cap_bit[k] !== eb) bits_ok = 0;
      if (cap_oe[k] !== eo) oe_ok = 0;
    end
    check(bits_ok, "R5", "frame bits", w, w);
    check(oe_ok, "R7", "drive pattern", {31'h0, rd}, {31'h0, rd});
    check(per_bad == 0, "R6", "mdc period", per_bad, 0);
    check(hi_cnt == FLEN * HALF, "R6", "mdc high cycles", hi_cnt, FLEN * HALF);
    check(stab_bad == 0, "R9", "mdio moved while mdc high", stab_bad, 0);
    reg_get(A_MAINT, m);
    check(m == exp_maint, rd ? "R8" : "R5", "maint after frame", m, exp_maint);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r, w1, w2;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    reg_get(A_CTRL, r);  check(r == 32'h0, "R1", "ctrl reset", r, 32'h0);
    reg_get(A_STAT, r);  check(r == 32'h4, "R1", "status reset", r, 32'h4);
    reg_get(A_MAINT, r); check(r == 32'h0, "R1", "maint reset", r, 32'h0);
    check(mdc_o == 1'b0 && mdio_oe_o == 1'b0, "R1", "pins reset", {mdc_o, mdio_oe_o}, 0);

    // R2 disabled port ignores commands
    clear_mon();
    reg_write(A_MAINT, mk_word(1, 5, 1, 16'h0));
    reg_get(A_STAT, r);  check(r[2] == 1'b1, "R2", "idle while disabled", r, 32'h4);
    repeat (2 * DIV) @(negedge clk_i);
    reg_get(A_MAINT, r); check(r == 32'h0, "R2", "maint while disabled", r, 32'h0);
    check(hi_cnt == 0, "R2", "mdc while disabled", hi_cnt, 0);

    // R10 register map
    reg_write(A_CTRL, 32'hFFFF_FFFF);
    reg_get(A_CTRL, r);  check(r == 32'h10, "R10", "ctrl mask", r, 32'h10);
    reg_write(A_CTRL, 32'hFFFF_FFEF);
    reg_get(A_CTRL, r);  check(r == 32'h0, "R2", "enable clear", r, 32'h0);
    reg_write(A_CTRL, 32'h10);
    reg_get(A_NONE, r);  check(r == 32'h0, "R10", "unused address", r, 32'h0);
    reg_get(A_STAT, r);  check(r == 32'h4, "R10", "status bits", r, 32'h4);

    // sweep all PHY addresses, read and write
    for (int p = 0; p < 32; p++) begin
      int rg = (p * 7 + 3) % 32;
      logic [15:0] wd = 16'h5A3C ^ (16'(p) * 16'h0801);
      phy_data = 16'hA5C3 ^ (16'(p) * 16'h0111);
      if (p == 0)  phy_data = 16'h0000;
      if (p == 31) phy_data = 16'hFFFF;
      w1 = mk_word(1, p, rg, 16'h0);
      start_cmd(w1);
      finish_cmd(w1, FLEN * DIV, {w1[31:16], phy_data});
      w1 = mk_word(0, p, 31 - rg, wd);
      start_cmd(w1);
      finish_cmd(w1, FLEN * DIV, w1);
    end

    // R4 write while busy
    w1 = mk_word(0, 9, 4, 16'hC0DE);
    w2 = mk_word(1, 22, 17, 16'h0);
    start_cmd(w1);
    repeat (20) @(negedge clk_i);
    reg_write(A_MAINT, w2);
    reg_get(A_MAINT, r); check(r == w1, "R4", "maint held busy", r, w1);
    finish_cmd(w1, FLEN * DIV - 22, w1);

    // R2 abort mid-frame
    phy_data = 16'h1234;
    w1 = mk_word(1, 3, 2, 16'h0);
    start_cmd(w1);
    repeat (50) @(negedge clk_i);
    reg_write(A_CTRL, 32'h0);
    reg_get(A_STAT, r); check(r[2] == 1'b1, "R2", "idle after abort", r, 32'h4);
    check(mdc_o == 1'b0 && mdio_oe_o == 1'b0, "R2", "pins after abort", {mdc_o, mdio_oe_o}, 0);
    r = rise_cnt;
    repeat (3 * DIV) @(negedge clk_i);
    check(rise_cnt == int'(r), "R2", "no mdc after abort", rise_cnt, r);
    reg_write(A_CTRL, 32'h10);
    phy_data = 16'hBEEF;
    w1 = mk_word(1, 17, 30, 16'h0);
    start_cmd(w1);
    finish_cmd(w1, FLEN * DIV, {w1[31:16], phy_data});

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule